// File: doc/BRIEF.md
# Dual-Mode 16-bit Interval Timer

This block is one down-counter that serves two jobs. In waveform mode it counts from a loaded start value down through zero and toggles a timer output each time it wraps. It can either keep running by reloading, or halt after the first wrap. In edge-measurement mode it counts down between transitions on a synchronized input. On a transition it latches the running count into a capture register and restarts from the loaded value. It can either do this on every transition, or only on the first one after it is armed.

A prescaler feeds the counter with the system clock divided by 1, 2, 4 or 8. Two sticky flags record a terminal count and a capture. Software clears each flag by writing 1 to it. Each flag drives a level interrupt through its own mask. The output pin shows either a general-purpose port bit or the timer output.

Software reaches the block through a byte-wide register port with four addresses.

| Address | Read | Write |
|---|---|---|
| 0 | control byte | control byte |
| 1 | status | status (write-1-to-clear) |
| 2 | captured count, low byte | start value, low byte |
| 3 | captured count, high byte | start value, high byte |

Control byte fields:

| Bits | Field |
|---|---|
| 0 | run |
| 1 | single-shot |
| 2 | edge-measurement mode |
| 4:3 | divider code |
| 5 | capture interrupt mask |
| 6 | timeout interrupt mask |
| 7 | pin select |

Status bits: bit 0 is the timeout flag and bit 1 is the capture flag.

Top module: `ivl_timer`

## Requirements
- R1: After reset the control byte and status read back as 0, both interrupts are low, the counter is stopped, and `pin_out` equals `port_bit`.
- R2: With divider code c (divide by d = 2^c) and start value N, writing run from 0 to 1 sets the timeout flag exactly (N+1)·d clock edges after the edge of that write.
- R3: In waveform mode with single-shot 0, the counter reloads N at each terminal count. Terminal count then repeats every (N+1)·d edges, and the timer output toggles at each one.
- R4: In waveform mode with single-shot 1, the counter halts after the first terminal count. No further timeout is flagged and the timer output stays put.
- R5: While run is 0 the counter holds, and no terminal count occurs.
- R6: The timeout flag (status bit 0) stays set until a write to status with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R7: `irq_to` is high exactly when the timeout flag and the timeout mask (control bit 6) are both 1.
- R8: In edge-measurement mode with single-shot 0, every rising or falling transition of `demod_in` is acted on at the third clock edge after it changes. At that edge the count held just before it is captured and the counter reloads N.
- R9: In edge-measurement mode with single-shot 1, only the first transition after run goes from 0 to 1 is captured. Later transitions leave the capture register and the capture flag unchanged until run is written from 0 to 1 again.
- R10: A capture latches all 16 bits in one edge, readable as low (address 2) and high (address 3) bytes. It sets the capture flag (status bit 1, cleared by writing 1 to it), and `irq_cap` is that flag AND the capture mask (control bit 5).
- R11: `pin_out` follows `port_bit` when control bit 7 is 0 and the timer output when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 2 | register address |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data for `addr` (combinational) |
| port_bit | input | 1 | general-purpose output value for the pin |
| demod_in | input | 1 | asynchronous input whose transitions are measured |
| pin_out | output | 1 | muxed output pin |
| irq_cap | output | 1 | capture interrupt (level) |
| irq_to | output | 1 | timeout interrupt (level) |

## Verification
A wrong count or prescaler phase shows as a timeout flag arriving one or more edges early or late. The bench pins the arrival to a single edge for every divider code and several start values, so such an error shows within one period. A broken reload or a broken halt shows on the second period, as a toggle of `pin_out` that is missing or comes at the wrong time. A wrong synchronizer depth or a stale capture shows directly in the captured bytes, which are compared against a count computed from the number of edges since the last reload.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = CNT_W / BYTE_W;
    localparam int SEL_W   = 2;
    localparam int PRE_W   = (1 << SEL_W) - 1;
    localparam int A_CTRL  = 0;
    localparam int A_STAT  = 1;
    localparam int A_DATA0 = 2;
    localparam int ADDR_W  = $clog2(A_DATA0 + NBYTES);
    localparam int ST_TO   = 0;
    localparam int ST_CAP  = 1;

    typedef enum logic [SEL_W-1:0] {DIV1, DIV2, DIV4, DIV8} div_e;

    typedef struct packed {
        logic out_sel;
        logic to_mask;
        logic cap_mask;
        div_e div;
        logic demod;
        logic one_shot;
        logic run;
    } ctrl_t;

    function automatic logic [PRE_W-1:0] div_mask(div_e d);
        return PRE_W'((1 << d) - 1);
    endfunction
endpackage

// File: rtl/ivl_prescale.sv
module ivl_prescale
    import ivl_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  div_e div,
    output logic tick
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] msk;

    always_comb begin
        msk  = div_mask(div);
        tick = run && ((cnt & msk) == msk);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (div != DIV1 && $past(tick) && $stable(div)) |-> !tick);
endmodule

// File: rtl/ivl_edge_sync.sv
module ivl_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_seen
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], din};
    end

    assign edge_seen = sh[2] ^ sh[1];
endmodule

// File: rtl/ivl_count_core.sv
module ivl_count_core
    import ivl_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic             one_shot,
    input  logic             demod,
    input  logic             tick,
    input  logic             edge_seen,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_evt,
    output logic             tc,
    output logic             tmr_out
);
    logic [CNT_W-1:0] count;
    logic             stopped;
    logic             armed;

    always_comb begin
        cap_evt = run && demod && edge_seen && (!one_shot || armed);
        tc      = run && tick && !stopped && (count == '0) && !cap_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            stopped <= 1'b0;
            armed   <= 1'b0;
            tmr_out <= 1'b0;
            cap_val <= '0;
        end else if (start) begin
            count   <= reload;
            stopped <= 1'b0;
            armed   <= 1'b1;
        end else if (cap_evt) begin
            cap_val <= count;
            count   <= reload;
            if (one_shot) armed <= 1'b0;
        end else if (tc) begin
            if (!demod && one_shot) stopped <= 1'b1;
            else                    count   <= reload;
            if (!demod) tmr_out <= ~tmr_out;
        end else if (run && tick && !stopped) begin
            count <= count - 1'b1;
        end
    end

    a_r3_reload_at_tc: assert property (@(posedge clk) disable iff (rst)
        (tc && !demod && !one_shot) |=> count == $past(reload));
    a_r4_halted_holds: assert property (@(posedge clk) disable iff (rst)
        (stopped && !start && !demod) |=> ($stable(count) && $stable(tmr_out)));
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(count));
    a_r10_capture_whole: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> cap_val == $past(count));
    a_r9_disarmed_holds: assert property (@(posedge clk) disable iff (rst)
        (demod && one_shot && !armed && !start) |=> $stable(cap_val));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              port_bit,
    input  logic              demod_in,
    output logic              pin_out,
    output logic              irq_cap,
    output logic              irq_to
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cap_val;
    logic             to_flag, cap_flag;
    logic             tick, edge_seen, cap_evt, tc, tmr_out;
    logic             wr_ctrl, wr_stat, start;

    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
        wr_stat = wr_en && (addr == ADDR_W'(A_STAT));
        start   = wr_ctrl && wdata[0] && !ctrl.run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            to_flag  <= 1'b0;
            cap_flag <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata);
            to_flag  <= tc      | (to_flag  & ~(wr_stat & wdata[ST_TO]));
            cap_flag <= cap_evt | (cap_flag & ~(wr_stat & wdata[ST_CAP]));
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_reload
        always_ff @(posedge clk) begin
            if (rst) reload[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && addr == ADDR_W'(A_DATA0 + b))
                reload[b*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL)) rdata = ctrl;
        if (addr == ADDR_W'(A_STAT)) begin
            rdata[ST_TO]  = to_flag;
            rdata[ST_CAP] = cap_flag;
        end
        for (int b = 0; b < NBYTES; b++)
            if (addr == ADDR_W'(A_DATA0 + b)) rdata = cap_val[b*BYTE_W +: BYTE_W];
    end

    assign pin_out = ctrl.out_sel ? tmr_out : port_bit;
    assign irq_to  = to_flag & ctrl.to_mask;
    assign irq_cap = cap_flag & ctrl.cap_mask;

    ivl_prescale u_pre (
        .clk(clk), .rst(rst), .run(ctrl.run), .div(ctrl.div), .tick(tick)
    );

    ivl_edge_sync u_sync (
        .clk(clk), .rst(rst), .din(demod_in), .edge_seen(edge_seen)
    );

    ivl_count_core u_core (
        .clk(clk), .rst(rst), .run(ctrl.run), .start(start),
        .one_shot(ctrl.one_shot), .demod(ctrl.demod), .tick(tick),
        .edge_seen(edge_seen), .reload(reload), .cap_val(cap_val),
        .cap_evt(cap_evt), .tc(tc), .tmr_out(tmr_out)
    );

    a_r6_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
        (to_flag && !(wr_stat && wdata[ST_TO])) |=> to_flag);
    a_r10_capture_sticky: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !(wr_stat && wdata[ST_CAP])) |=> cap_flag);
endmodule

// File: tb/test_ivl_timer.sv
module test_ivl_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       port_bit = 1'b0;
    logic       demod_in = 1'b0;
    logic       pin_out, irq_cap, irq_to;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ivl_timer i_ivl_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .port_bit(port_bit), .demod_in(demod_in),
        .pin_out(pin_out), .irq_cap(irq_cap), .irq_to(irq_to)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd16(output int v);
        logic [7:0] lo, hi;
        rd(2'd2, lo);
        rd(2'd3, hi);
        v = {hi, lo};
    endtask

    task automatic set_reload(input int n);
        wr(2'd2, n[7:0]);
        wr(2'd3, n[15:8]);
    endtask

    task automatic idle();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h03);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int v, p0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(2'd0, d); check(d == 0, "R1 ctrl", d, 0);
        rd(2'd1, d); check(d == 0, "R1 status", d, 0);
        check(!irq_to && !irq_cap, "R1 irqs", irq_to + irq_cap, 0);
        // R11 pin follows port bit when select is 0
        port_bit = 1'b1; #1; check(pin_out == 1'b1, "R11 port 1", pin_out, 1);
        port_bit = 1'b0; #1; check(pin_out == 1'b0, "R11 port 0", pin_out, 0);

        // R2 sweep of divider codes and start values
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 4; k++) begin
                int n, dv;
                n = (k == 3) ? 5 : k;
                dv = 1 << c;
                idle();
                set_reload(n);
                wr(2'd0, 8'h41 | (c << 3));
                step((n + 1) * dv - 1);
                check(irq_to == 1'b0, "R2 early", irq_to, 0);
                step(1);
                check(irq_to == 1'b1, "R2 on time", irq_to, 1);
            end
        end

        // R3 continuous waveform, N=3, divide by 2: period 8 edges
        idle();
        set_reload(3);
        wr(2'd0, 8'h89);
        p0 = pin_out;
        step(7); check(pin_out == p0, "R3 before tc", pin_out, p0);
        step(1); check(pin_out != p0, "R3 first toggle", pin_out, !p0);
        step(7); check(pin_out != p0, "R3 mid period", pin_out, !p0);
        step(1); check(pin_out == p0, "R3 second toggle", pin_out, p0);
        // R11 pin follows timer, not port bit
        port_bit = ~pin_out; #1;
        check(pin_out == p0, "R11 timer select", pin_out, p0);
        port_bit = 1'b0;

        // R4 single-shot waveform, N=2
        idle();
        set_reload(2);
        wr(2'd0, 8'h83);
        p0 = pin_out;
        step(2); rd(2'd1, d); check(d[0] == 1'b0, "R4 early", d[0], 0);
        step(1); rd(2'd1, d); check(d[0] == 1'b1, "R4 tc", d[0], 1);
        check(pin_out != p0, "R4 toggle", pin_out, !p0);
        wr(2'd1, 8'h01);
        step(20); rd(2'd1, d); check(d[0] == 1'b0, "R4 halted flag", d[0], 0);
        check(pin_out != p0, "R4 halted pin", pin_out, !p0);

        // R5 run cleared holds counter
        idle();
        set_reload(4);
        wr(2'd0, 8'h01);
        step(1);
        wr(2'd0, 8'h00);
        step(30); rd(2'd1, d); check(d[0] == 1'b0, "R5 no timeout", d[0], 0);

        // R6 / R7 flag and mask
        idle();
        set_reload(0);
        wr(2'd0, 8'h01);
        step(2);
        wr(2'd0, 8'h00);
        rd(2'd1, d); check(d[0] == 1'b1, "R6 set", d[0], 1);
        check(irq_to == 1'b0, "R7 masked", irq_to, 0);
        wr(2'd0, 8'h40);
        check(irq_to == 1'b1, "R7 unmasked", irq_to, 1);
        wr(2'd1, 8'h00);
        rd(2'd1, d); check(d[0] == 1'b1, "R6 write 0 ignored", d[0], 1);
        wr(2'd1, 8'h01);
        rd(2'd1, d); check(d[0] == 1'b0, "R6 cleared", d[0], 0);
        check(irq_to == 1'b0, "R7 cleared", irq_to, 0);

        // R8 / R10 edge measurement every transition, N=1000
        idle();
        set_reload(1000);
        wr(2'd0, 8'h25);
        step(10); demod_in = ~demod_in;
        step(2); check(irq_cap == 1'b0, "R8 latency", irq_cap, 0);
        step(1); check(irq_cap == 1'b1, "R10 irq", irq_cap, 1);
        rd16(v); check(v == 988, "R8 first capture", v, 988);
        demod_in = ~demod_in;
        step(3); rd16(v); check(v == 998, "R8 back to back", v, 998);
        step(5); demod_in = ~demod_in;
        step(3); rd16(v); check(v == 993, "R8 later edge", v, 993);
        wr(2'd1, 8'h02);
        check(irq_cap == 1'b0, "R10 flag clear", irq_cap, 0);
        wr(2'd0, 8'h05);
        demod_in = ~demod_in;
        step(3); rd(2'd1, d);
        check(d[1] == 1'b1 && irq_cap == 1'b0, "R10 masked", irq_cap, 0);

        // R9 first-transition only, with re-arm
        idle();
        wr(2'd0, 8'h27);
        step(4); demod_in = ~demod_in;
        step(3); rd16(v); check(v == 994, "R9 first", v, 994);
        check(irq_cap == 1'b1, "R9 flag", irq_cap, 1);
        wr(2'd1, 8'h02);
        demod_in = ~demod_in;
        step(5); check(irq_cap == 1'b0, "R9 ignored flag", irq_cap, 0);
        rd16(v); check(v == 994, "R9 ignored value", v, 994);
        wr(2'd0, 8'h26);
        wr(2'd0, 8'h27);
        demod_in = ~demod_in;
        step(3); rd16(v); check(v == 998, "R9 rearmed", v, 998);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule